// File: doc/BRIEF.md
# State-Space Controller Step Engine (Distributed Arithmetic)

This block computes one sampling step of a discrete linear time-invariant controller. A controller with P sensor inputs, N internal states and Q actuator outputs is written as one fixed coefficient matrix of N+Q rows applied to the stacked operand vector whose first N elements are the stored state and whose last P elements are the sensor samples. The first N rows give the next state and the last Q rows give the actuator outputs. The block evaluates every row in the same pass, so the next state and the outputs are both complete well before the next sample instant.

Each row is a distributed arithmetic dot product. Its lookup table covers only the columns where the row has a nonzero coefficient, so a sparse row needs a much smaller table than a full one. The table is built at elaboration from the coefficient parameter. All row datapaths share one bit-slice counter. K operand bits are consumed per cycle, which gives W/K cycles per evaluation. The two's-complement sign bit is given negative weight. Each row result is arithmetically shifted right by FRAC fractional bits and then clamped to a W-bit signed word. The new state is written back only when all rows have finished, so every row reads the old state.

A host pulses `sample_i` with the sensor words on `u_i`. It then waits for the one-cycle `y_valid_o` pulse and reads `y_o`. W must be a multiple of K.

Top module: `ss_da_ctrl`

## Requirements
- R1: After reset, `y_o` is 0, `y_valid_o`, `busy_o` and `overrun_o` are 0, and the stored state is all zero. As a result, a first sample with all sensor inputs at zero yields `y_o` = 0.
- R2: A `sample_i` seen high at a rising edge while `busy_o` is low starts an evaluation. `busy_o` is high from that edge on. `y_valid_o` is high for exactly one cycle, after the (W/K+1)-th rising edge counted from and including the starting edge (11 edges with the defaults). `busy_o` is low in that cycle.
- R3: Output j (bits [j*W +: W] of `y_o`) equals clamp((sum over c of M[N+j][c]·v[c]) >>> FRAC). Here v[0..N-1] is the state before the step and v[N+i] is sensor i (bits [i*W +: W] of `u_i`). The shift is arithmetic, and the clamp limits are -2^(W-1) and 2^(W-1)-1.
- R4: At the edge that raises `y_valid_o`, state i becomes clamp((sum over c of M[i][c]·v[c]) >>> FRAC), using the same old-state operand vector. That new state feeds the following step.
- R5: Sensor words are W-bit two's complement, and the full range, including -2^(W-1), is handled exactly.
- R6: A row result above 2^(W-1)-1 after the shift is output as 2^(W-1)-1. A result below -2^(W-1) is output as -2^(W-1). This holds for outputs and for stored states alike.
- R7: A `sample_i` pulse seen while `busy_o` is high is dropped and sets `overrun_o`. The flag stays set until reset. The running evaluation's results, and the number of state updates, are unchanged.
- R8: `y_o` holds its value in every cycle in which `y_valid_o` is low.
- R9: `u_i` is sampled only at the starting edge. Changes to it while `busy_o` is high do not affect the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_i | input | 1 | Sample strobe, starts one controller step |
| u_i | input | P*W | Sensor words, sensor i at bits [i*W +: W], signed |
| y_o | output | Q*W | Actuator words, output j at bits [j*W +: W], signed |
| y_valid_o | output | 1 | One-cycle pulse when a step completes |
| busy_o | output | 1 | Evaluation in progress |
| overrun_o | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge and that `sample_i` is driven only from a clock-synchronous source. Under those assumptions, the cycle counts of the busy window and the stability of `y_o` are meaningful. The bench drives every input at the falling edge. It waits four cycles after reset release, to let the internal synchronizer settle, before the first strobe. It raises a strobe during a busy window only in the scenario that targets the overrun flag. Sensor words span the whole signed range, so the sign-bit slice and both saturation limits are reached without ever exceeding the declared input width.

// File: rtl/ss_da_pkg.sv
package ss_da_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int bits_for(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/ss_da_seq.sv
module ss_da_seq
  import ss_da_pkg::*;
#(
  parameter int NCYC = 10,
  localparam int CNTW = bits_for(NCYC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  output logic            busy_o,
  output logic            start_o,
  output logic            last_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            overrun_o
);

  localparam logic [CNTW-1:0] LAST_CNT = CNTW'(NCYC - 1);

  seq_state_e      st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ovr_q, ovr_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (sample_i) begin
          st_d  = SEQ_RUN;
          cnt_d = '0;
        end
      end
      SEQ_RUN: begin
        if (sample_i) ovr_d = 1'b1;
        if (cnt_q == LAST_CNT) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign busy_o    = (st_q == SEQ_RUN);
  assign start_o   = (st_q == SEQ_IDLE) && sample_i;
  assign last_o    = (st_q == SEQ_RUN) && (cnt_q == LAST_CNT);
  assign cnt_o     = cnt_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/ss_da_row.sv
module ss_da_row
  import ss_da_pkg::*;
#(
  parameter int W    = 20,
  parameter int K    = 2,
  parameter int CW   = 16,
  parameter int COLS = 5,
  parameter int FRAC = 8,
  parameter int NCYC = W / K,
  parameter logic [COLS*CW-1:0] ROW_COEF = '0,
  localparam int CNTW = bits_for(NCYC),
  localparam int LW   = CW + bits_for(COLS) + 1,
  localparam int ACCW = LW + W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic [COLS*W-1:0] v_i,
  output logic [W-1:0]    word_o
);

  function automatic int nz_count();
    int n;
    n = 0;
    for (int c = 0; c < COLS; c++)
      if (ROW_COEF[c*CW +: CW] != '0) n++;
    return n;
  endfunction

  function automatic int col_of(input int slot);
    int n;
    n = 0;
    for (int c = 0; c < COLS; c++) begin
      if (ROW_COEF[c*CW +: CW] != '0) begin
        if (n == slot) return c;
        n++;
      end
    end
    return 0;
  endfunction

  localparam int E  = nz_count();
  localparam int EA = (E == 0) ? 1 : E;

  function automatic logic signed [LW-1:0] lut_val(input int a);
    logic signed [LW-1:0] s;
    logic signed [CW-1:0] cf;
    s = '0;
    for (int k = 0; k < E; k++) begin
      if (a[k]) begin
        cf = ROW_COEF[col_of(k)*CW +: CW];
        s  = s + LW'(cf);
      end
    end
    return s;
  endfunction

  localparam logic signed [ACCW-1:0] WMAX = {{(ACCW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACCW-1:0] WMIN = ~WMAX;

  logic signed [LW-1:0] lut [2**EA];
  logic [W-1:0]         opw [EA];

  for (genvar a = 0; a < 2**EA; a++) begin : g_lut
    assign lut[a] = lut_val(a);
  end

  if (E == 0) begin : g_empty
    assign opw[0] = '0;
  end else begin : g_sel
    for (genvar k = 0; k < E; k++) begin : g_col
      assign opw[k] = v_i[col_of(k)*W +: W];
    end
  end

  logic signed [ACCW-1:0] acc_q, acc_d, acc_next, lane_sum, term, sh;
  logic [EA-1:0]          addr;
  int                     bidx;

  always_comb begin
    lane_sum = '0;
    addr     = '0;
    bidx     = 0;
    term     = '0;
    for (int l = 0; l < K; l++) begin
      bidx = int'(cnt_i) * K + l;
      for (int k = 0; k < EA; k++) addr[k] = opw[k][bidx];
      term = ACCW'(lut[addr]);
      if (bidx == W - 1) term = -term;
      lane_sum = lane_sum + (term <<< l);
    end
    acc_next = acc_q + (lane_sum <<< (int'(cnt_i) * K));
  end

  always_comb begin
    acc_d = acc_q;
    if (clr_i)     acc_d = '0;
    else if (en_i) acc_d = acc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_comb begin
    sh = acc_next >>> FRAC;
    if (sh > WMAX)      word_o = WMAX[W-1:0];
    else if (sh < WMIN) word_o = WMIN[W-1:0];
    else                word_o = sh[W-1:0];
  end

endmodule

// File: rtl/ss_da_ctrl.sv
module ss_da_ctrl
  import ss_da_pkg::*;
#(
  parameter int P    = 3,
  parameter int N    = 2,
  parameter int Q    = 1,
  parameter int W    = 20,
  parameter int K    = 2,
  parameter int CW   = 16,
  parameter int FRAC = 8,
  parameter logic [(N+Q)*(N+P)*CW-1:0] COEF = {
    16'h0078, 16'hFED4, 16'h0190, 16'hFFB0, 16'h0060,
    16'h0000, 16'hFFD0, 16'h0000, 16'h00C8, 16'h0000,
    16'h0000, 16'h0000, 16'h012C, 16'h0000, 16'h00E6
  }
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_i,
  input  logic [P*W-1:0] u_i,
  output logic [Q*W-1:0] y_o,
  output logic         y_valid_o,
  output logic         busy_o,
  output logic         overrun_o
);

  localparam int ROWS = N + Q;
  localparam int COLS = N + P;
  localparam int NCYC = W / K;
  localparam int CNTW = bits_for(NCYC);

  logic            rs1_q, rs2_q;
  logic            start, last, busy;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  ss_da_seq #(.NCYC(NCYC)) u_seq (
    .clk       (clk),
    .rst_n     (rs2_q),
    .sample_i  (sample_i),
    .busy_o    (busy),
    .start_o   (start),
    .last_o    (last),
    .cnt_o     (cnt),
    .overrun_o (overrun_o)
  );

  logic [P*W-1:0]    u_q, u_d;
  logic [N*W-1:0]    x_q, x_d;
  logic [Q*W-1:0]    y_q, y_d;
  logic              vld_q;
  logic [ROWS*W-1:0] row_res;
  logic [COLS*W-1:0] v;

  assign v = {u_q, x_q};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    ss_da_row #(
      .W(W), .K(K), .CW(CW), .COLS(COLS), .FRAC(FRAC), .NCYC(NCYC),
      .ROW_COEF(COEF[r*COLS*CW +: COLS*CW])
    ) u_row (
      .clk    (clk),
      .rst_n  (rs2_q),
      .clr_i  (start),
      .en_i   (busy),
      .cnt_i  (cnt),
      .v_i    (v),
      .word_o (row_res[r*W +: W])
    );
  end

  always_comb begin
    u_d = start ? u_i : u_q;
    x_d = last ? row_res[N*W-1:0] : x_q;
    y_d = last ? row_res[ROWS*W-1 -: Q*W] : y_q;
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      u_q   <= '0;
      x_q   <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      u_q   <= u_d;
      x_q   <= x_d;
      y_q   <= y_d;
      vld_q <= last;
    end
  end

  assign y_o       = y_q;
  assign y_valid_o = vld_q;
  assign busy_o    = busy;

endmodule

// File: rtl/ss_da_ctrl_chk.sv
module ss_da_ctrl_chk #(
  parameter int QW   = 20,
  parameter int NCYC = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_i,
  input logic          busy_o,
  input logic          y_valid_o,
  input logic          overrun_o,
  input logic [QW-1:0] y_o
);

  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!busy_o) run_q <= '0;
    else             run_q <= run_q + 16'd1;
  end

  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid_o |-> (run_q == 16'(NCYC)));  // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid_o |=> !y_valid_o);  // R2

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid_o |-> !busy_o);  // R2

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sample_i) |=> overrun_o);  // R7

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);  // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid_o |-> $stable(y_o));  // R8

endmodule

bind ss_da_ctrl ss_da_ctrl_chk #(.QW(Q*W), .NCYC(NCYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_i  (sample_i),
  .busy_o    (busy_o),
  .y_valid_o (y_valid_o),
  .overrun_o (overrun_o),
  .y_o       (y_o)
);

// File: tb/ss_da_ctrl_tb.sv
module ss_da_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P = 3, N = 2, Q = 1, W = 20, K = 2, CW = 16, FRAC = 8;
  localparam int ROWS = N + Q, COLS = N + P;
  localparam int NCYC = W / K;
  localparam longint WMAXV = (64'sd1 <<< (W - 1)) - 1;
  localparam longint WMINV = -(64'sd1 <<< (W - 1));

  localparam int CF [15] = '{230, 0, 300, 0, 0,
                             0, 200, 0, -48, 0,
                             96, -80, 400, -300, 120};

  function automatic logic [ROWS*COLS*CW-1:0] pack_coef();
    logic [ROWS*COLS*CW-1:0] f;
    for (int i = 0; i < ROWS*COLS; i++) f[i*CW +: CW] = CW'(CF[i]);
    return f;
  endfunction

  logic           clk, rst_n, sample_i;
  logic [P*W-1:0] u_i;
  logic [Q*W-1:0] y_o;
  logic           y_valid_o, busy_o, overrun_o;

  int     n_run, n_fail;
  bit     done;
  longint xm [N];

  ss_da_ctrl #(.P(P), .N(N), .Q(Q), .W(W), .K(K), .CW(CW), .FRAC(FRAC),
               .COEF(pack_coef())) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .u_i(u_i),
    .y_o(y_o), .y_valid_o(y_valid_o), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampw(input longint v);
    if (v > WMAXV) return WMAXV;
    if (v < WMINV) return WMINV;
    return v;
  endfunction

  // Runs one step; mode 0 plain, 1 scramble u while busy (R9), 2 extra strobe while busy (R7)
  task automatic do_step(input longint u0, input longint u1, input longint u2, input int mode);
    longint vv [COLS];
    longint rr [ROWS];
    longint yprev;
    int     edges;
    bit     hold_ok;
    vv[0] = xm[0]; vv[1] = xm[1]; vv[2] = u0; vv[3] = u1; vv[4] = u2;
    for (int r = 0; r < ROWS; r++) begin
      longint s;
      s = 0;
      for (int c = 0; c < COLS; c++) s += longint'(CF[r*COLS+c]) * vv[c];
      rr[r] = clampw(s >>> FRAC);
    end
    yprev = longint'($signed(y_o));
    @(negedge clk);
    u_i = {W'(u2), W'(u1), W'(u0)};
    sample_i = 1'b1;
    @(posedge clk);
    edges = 1;
    hold_ok = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    if (mode == 1) u_i = ~u_i;
    while (!y_valid_o && edges < 40) begin
      if (longint'($signed(y_o)) != yprev) hold_ok = 1'b0;
      if (mode == 2 && edges == 3) sample_i = 1'b1;
      else sample_i = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
      sample_i = 1'b0;
    end
    check(edges == NCYC + 1, "R2 latency", edges, NCYC + 1);
    check(hold_ok, "R8 y held while not valid", 0, 1);
    check(longint'($signed(y_o)) == rr[2], "R3/R4/R5/R6 y value", longint'($signed(y_o)), rr[2]);
    @(negedge clk);
    check(!y_valid_o, "R2 single-cycle pulse", y_valid_o, 0);
    xm[0] = rr[0];
    xm[1] = rr[1];
  endtask

  task automatic t_reset();
    check(y_o == '0, "R1 y reset", longint'(y_o), 0);
    check(!y_valid_o, "R1 valid reset", y_valid_o, 0);
    check(!busy_o, "R1 busy reset", busy_o, 0);
    check(!overrun_o, "R1 overrun reset", overrun_o, 0);
    do_step(0, 0, 0, 0);
    check(y_o == '0, "R1 zero state gives zero", longint'(y_o), 0);
  endtask

  task automatic t_patterns();  // R3 R4
    do_step(1000, -2000, 3000, 0);
    do_step(-5000, 7000, -100, 0);
    do_step(123456, -98765, 4321, 0);
    do_step(0, 0, 0, 0);
    do_step(0, 0, 0, 0);
  endtask

  task automatic t_extremes();  // R5 R6
    do_step(WMINV, WMINV, WMINV, 0);
    do_step(WMAXV, WMINV, WMAXV, 0);
    check(longint'($signed(y_o)) == WMAXV, "R6 positive clamp", longint'($signed(y_o)), WMAXV);
    do_step(WMINV, WMAXV, WMINV, 0);
    check(longint'($signed(y_o)) == WMINV, "R6 negative clamp", longint'($signed(y_o)), WMINV);
    do_step(0, 0, 0, 0);
  endtask

  task automatic t_scramble();  // R9
    do_step(20000, -30000, 40000, 1);
    do_step(0, 0, 0, 0);
  endtask

  task automatic t_overrun();  // R7
    check(!overrun_o, "R7 no overrun before", overrun_o, 0);
    do_step(-77777, 55555, 33333, 2);
    check(overrun_o, "R7 overrun set", overrun_o, 1);
    do_step(0, 0, 0, 0);
    check(overrun_o, "R7 overrun sticky", overrun_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    xm[0] = 0;
    xm[1] = 0;
    rst_n = 1'b0;
    sample_i = 1'b0;
    u_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_patterns();
    t_extremes();
    t_scramble();
    t_overrun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule